// File: doc/BRIEF.md
# Two-level peripheral interrupt aggregator

This block gathers a vector of single-cycle interrupt events from a group of peripheral sources. Each event is latched into its own sticky flag bit. A per-bit enable mask gates the flags, and the gated flags are OR-ed into one level-sensitive request line for a top-level interrupt controller. Software sees two registers through a small port made of a write enable, a one-bit address, write data and combinational read data.

The enable register is a plain read/write mask. Flag bits are write-1-to-clear, and a flag always captures its event whatever the mask holds. When a clear meets a fresh event on the same bit in the same cycle, the flag stays set, so no event is lost. The request line is computed from the next-state values of both registers and registered. It therefore changes on the same clock edge as the register contents it reflects, and it stays high for as long as any enabled flag is still set.

Top module: `irq_agg_top`

## Requirements
- R1: A synchronous active-high reset clears the enable register and the flag register to zero, and irq_out is low in the cycle after reset.
- R2: A 1 on bit i of src_evt at a rising edge sets flag bit i on that edge, whatever the value of enable bit i.
- R3: A write with reg_addr = 1 (flag register) clears every flag bit whose reg_wdata bit is 1. Flag bits whose reg_wdata bit is 0 keep their value.
- R4: When a clear of flag bit i and an event on src_evt bit i fall on the same edge, flag bit i is set after that edge.
- R5: A write with reg_addr = 0 (enable register) loads reg_wdata into the enable register on that edge. Without such a write the enable register holds its value.
- R6: After every edge, irq_out equals the OR over all bits of (flag AND enable), taken from the register values updated on that same edge.
- R7: Setting an enable bit whose flag is already set raises irq_out on the edge of the enable write.
- R8: irq_out stays high while at least one enabled flag remains set. Clearing only some of the enabled flags does not lower it.
- R9: reg_rdata returns the enable register when reg_addr = 0 and the flag register when reg_addr = 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | W | Single-cycle source events, one bit per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = enable, 1 = flag |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Combinational read data of the selected register |
| irq_out | output | 1 | Level-sensitive aggregated interrupt request |

## Verification
The bench runs a small 4-bit configuration. It sweeps every enable value against every event pattern and every clear pattern, and each clear comes together with a derived set of new events. This exposes a design that lets the mask gate event capture, since masked flags would read back zero. It also exposes a design that gives the clear priority, since coincident events would be lost. Directed steps enable a flag that is already pending and clear enabled flags one at a time. A design that samples the mask only on new events would miss the late enable, and one that pulses rather than holds the request would drop irq_out early.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  localparam logic SEL_MASK = 1'b0;
  localparam logic SEL_FLAG = 1'b1;
endpackage

// File: rtl/irq_agg_flags.sv
`timescale 1ns/1ps
module irq_agg_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_stb,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] flag_d
);
  // One sticky cell per source; a new event wins over a clear.
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic wipe;
    assign wipe      = clr_stb & clr_bits[i];
    assign flag_d[i] = evt[i] | (flag_q[i] & ~wipe);
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/irq_agg_mask.sv
`timescale 1ns/1ps
module irq_agg_mask #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] en_q,
  output logic [W-1:0] en_d
);
  assign en_d = ld ? din : en_q;
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/irq_agg_combine.sv
`timescale 1ns/1ps
module irq_agg_combine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flag_d,
  input  logic [W-1:0] en_d,
  output logic         irq_q
);
  logic [W-1:0] gated;
  for (genvar i = 0; i < W; i++) begin : g_gate
    assign gated[i] = flag_d[i] & en_d[i];
  end
  // Registered from next-state values: tracks the registers edge for edge.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |gated;
  end
endmodule

// File: rtl/irq_agg_top.sv
`timescale 1ns/1ps
module irq_agg_top #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_evt,
  input  logic         reg_we,
  input  logic         reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq_out
);
  import irq_agg_pkg::*;

  logic         wr_mask;
  logic         wr_flag;
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;
  logic [W-1:0] en_q;
  logic [W-1:0] en_d;

  assign wr_mask = reg_we & (reg_addr == SEL_MASK);
  assign wr_flag = reg_we & (reg_addr == SEL_FLAG);

  irq_agg_flags #(.W(W)) u_flags (
    .clk(clk), .rst(rst), .evt(src_evt),
    .clr_stb(wr_flag), .clr_bits(reg_wdata),
    .flag_q(flag_q), .flag_d(flag_d)
  );

  irq_agg_mask #(.W(W)) u_mask (
    .clk(clk), .rst(rst), .ld(wr_mask), .din(reg_wdata),
    .en_q(en_q), .en_d(en_d)
  );

  irq_agg_combine #(.W(W)) u_comb (
    .clk(clk), .rst(rst), .flag_d(flag_d), .en_d(en_d), .irq_q(irq_out)
  );

  assign reg_rdata = (reg_addr == SEL_FLAG) ? flag_q : en_q;
endmodule

// File: rtl/irq_agg_chk.sv
`timescale 1ns/1ps
module irq_agg_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] src,
  input logic         we,
  input logic         addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] flag,
  input logic [W-1:0] en,
  input logic         irq
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flag == '0 && en == '0 && !irq));
  // R2, R4
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (src != '0) |=> ((flag & $past(src)) == $past(src)));
  // R3
  a_r3_clear_ones: assert property (@(posedge clk) disable iff (rst)
    (we && addr) |=> ((flag & $past(wdata) & ~$past(src)) == '0));
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (we && addr) |=> ((flag & $past(flag) & ~$past(wdata)) == ($past(flag) & ~$past(wdata))));
  // R5
  a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
    (we && !addr) |=> (en == $past(wdata)));
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !(we && !addr) |=> $stable(en));
  // R6, R7, R8
  a_r6_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == ((flag & en) != '0)));
  // R9
  always_comb begin
    a_r9_read: assert (rdata == (addr ? flag : en));
  end
endmodule

bind irq_agg_top irq_agg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .src(src_evt), .we(reg_we), .addr(reg_addr),
  .wdata(reg_wdata), .rdata(reg_rdata), .flag(flag_q), .en(en_q), .irq(irq_out)
);

// File: tb/tb_irq_agg_top.sv
`timescale 1ns/100ps
module tb_irq_agg_top;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] src_evt = '0;
  logic         reg_we = 1'b0;
  logic         reg_addr = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         irq_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [W-1:0] m_flag = '0;
  logic [W-1:0] m_en = '0;
  logic [W-1:0] got_en, got_flag;
  logic         got_irq;

  always #2 clk = ~clk;

  irq_agg_top #(.W(W)) dut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, read back after it.
  task automatic step(input logic we, input logic a, input logic [W-1:0] wd,
                      input logic [W-1:0] s, input string ftag);
    logic [W-1:0] clr;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; src_evt = s;
    @(posedge clk);
    clr = (we && a) ? wd : '0;
    m_flag = (m_flag & ~clr) | s;
    if (we && !a) m_en = wd;
    #1;
    reg_we = 1'b0; src_evt = '0;
    got_irq = irq_out;
    reg_addr = 1'b0; #0.2; got_en = reg_rdata;
    reg_addr = 1'b1; #0.2; got_flag = reg_rdata;
    reg_addr = 1'b0;
    chk("R5 enable", got_en, m_en);
    chk(ftag, got_flag, m_flag);
    chk("R6 irq", {{(W-1){1'b0}}, got_irq}, {{(W-1){1'b0}}, |(m_flag & m_en)});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog got=%0d exp=<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state
    src_evt = '1; reg_we = 1'b1; reg_wdata = '1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; src_evt = '0; reg_we = 1'b0;
    chk("R1 irq low", {{(W-1){1'b0}}, irq_out}, '0);
    reg_addr = 1'b0; #0.2; chk("R1 enable zero", reg_rdata, '0);
    reg_addr = 1'b1; #0.2; chk("R1 flag zero", reg_rdata, '0);
    reg_addr = 1'b0;

    // R9: read mux with no clock delay
    step(1'b1, 1'b0, 4'b1010, 4'b0101, "R2 flag");
    @(negedge clk);
    reg_addr = 1'b0; #0.1; chk("R9 read enable", reg_rdata, 4'b1010);
    reg_addr = 1'b1; #0.1; chk("R9 read flag", reg_rdata, 4'b0101);
    reg_addr = 1'b0;
    step(1'b1, 1'b1, '1, '0, "R3 flag");

    // Exhaustive: enable e, events f, clear c with coincident events
    for (int e = 0; e < N; e++) begin
      for (int f = 0; f < N; f++) begin
        for (int c = 0; c < N; c++) begin
          logic [W-1:0] s2;
          s2 = W'((f ^ c) & (e | c));
          step(1'b1, 1'b0, W'(e), '0, "R5 flag");
          step(1'b0, 1'b0, '0, W'(f), "R2 flag");
          step(1'b1, 1'b1, W'(c), s2, "R4 flag");
          step(1'b1, 1'b1, '1, '0, "R3 flag");
        end
      end
    end

    // R7: enable a pending flag
    step(1'b1, 1'b0, '0, '0, "R5 flag");
    step(1'b0, 1'b0, '0, 4'b0100, "R2 flag");
    chk("R7 irq low while masked", {{(W-1){1'b0}}, got_irq}, '0);
    step(1'b1, 1'b0, 4'b0100, '0, "R7 flag");
    chk("R7 irq after late enable", {{(W-1){1'b0}}, got_irq}, 1);

    // R8: partial clears keep the line high
    step(1'b1, 1'b0, 4'b1101, 4'b1001, "R2 flag");
    step(1'b1, 1'b1, 4'b0100, '0, "R8 flag");
    chk("R8 irq held", {{(W-1){1'b0}}, got_irq}, 1);
    step(1'b1, 1'b1, 4'b0001, '0, "R8 flag");
    chk("R8 irq held", {{(W-1){1'b0}}, got_irq}, 1);
    step(1'b1, 1'b1, 4'b0000, '0, "R3 zero write");
    chk("R8 irq held", {{(W-1){1'b0}}, got_irq}, 1);
    step(1'b1, 1'b1, 4'b1000, '0, "R8 flag");
    chk("R8 irq dropped", {{(W-1){1'b0}}, got_irq}, 0);

    // R1: mid-run reset
    step(1'b1, 1'b0, '1, '1, "R2 flag");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_flag = '0; m_en = '0;
    chk("R1 irq after reset", {{(W-1){1'b0}}, irq_out}, '0);
    reg_addr = 1'b1; #0.2; chk("R1 flag after reset", reg_rdata, '0);
    reg_addr = 1'b0; #0.2; chk("R1 enable after reset", reg_rdata, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule